// File: doc/BRIEF.md
# Cascaded Interrupt Router and Vectorizer

This block collects two groups of interrupt request lines and merges them onto three processor interrupt levels. The first group has sixteen native device lines: lines 0 to 14 share one processor output, and line 15, the system timer, has an output of its own. The second group has sixteen legacy bus lines, which are latched into a pending register and masked by an enable register. That enable register and the end-of-interrupt clear are split into a low byte bank and a high byte bank. Each bank has its own two-address port.

Software reaches the block through a plain single-cycle register bus. Two read-only vector registers return priority-encoded source numbers, so a handler can find the lowest-numbered active source in one read. Reading or writing the native vector register acknowledges the shared native output. That output then stays quiet until a new native line rises or the native mask is rewritten. The block has no streaming data path, so every pin is a plain control or status signal and nothing applies back-pressure. A bus access always completes in the cycle it is presented.

All three outputs are registered. Each is computed from the state that the same clock edge loads. Any line, mask or clear change therefore shows at the outputs after exactly one rising edge.

Top module: `intr_cascade_router`

## Requirements
- R1: `irq_lvl6` is high exactly when native line 15 is high and native mask bit 15 is set. It follows a line or mask change after one rising edge, and native-vector accesses never lower it.
- R2: `irq_lvl3` is high only when some native line 0..14 is high with its mask bit set. Masked lines never raise it.
- R3: The native enable mask is read and written at address 0x0 and resets to 0x0000. Writing it re-arms `irq_lvl3`, so the new mask takes effect at the write edge.
- R4: A read of address 0x1 returns (i+1)<<2, where i is the lowest native line 0..14 that is high, whether or not that line is enabled. It returns 0 when none of lines 0..14 is high. Line 15 is never reported.
- R5: Any read or write of address 0x1 lowers `irq_lvl3` at that access edge. It stays low until one of native lines 0..14 goes from low to high, or the native mask is written.
- R6: A high legacy line sets its pending bit, and the bit stays set after the line drops. `irq_lvl4` is high exactly when some pending bit has its enable bit set.
- R7: The legacy enable mask resets to 0xFFFF, so every legacy line is enabled.
- R8: Writing address 0x5 loads enable bits 7:0 with the inverted low data byte, so a written 1 masks a line. Writing 0x7 does the same for bits 15:8. A read of 0x5 or 0x7 returns the whole 16-bit enable mask.
- R9: A write of any data to 0x4 clears pending bits 7:0, and a write to 0x6 clears bits 15:8. A line that is still high sets its bit again one edge later.
- R10: A read of address 0x2 returns the index of the lowest legacy line that is both pending and enabled. It returns 0 when there is none.
- R11: `bus_rdata` is loaded at the edge that takes a read and holds until the next read. Unmapped addresses read 0, and writes to read-only addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| nat_line | input | 16 | Native interrupt request levels; bit 15 is the timer |
| isa_line | input | 16 | Legacy bus interrupt request levels |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid from the edge after the read strobe |
| irq_lvl3 | output | 1 | Shared native interrupt (lines 0..14) |
| irq_lvl4 | output | 1 | Combined legacy interrupt |
| irq_lvl6 | output | 1 | Native timer interrupt (line 15) |

## Verification
Every output is computed from the state that its own clock edge loads. A wrong pending, mask or acknowledge bit therefore appears on an interrupt pin at the very next edge, with no accumulated delay. Corrupted enable bits can be read back at 0x5 or 0x7 as soon as the following read. A stuck acknowledge flag shows as `irq_lvl3` staying low after a fresh native line rises. A pending bit that the clear does not reach keeps `irq_lvl4` high and shows a stale index at 0x2 on the next read.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int NAT_LINES  = 16;
  localparam int ISA_LINES  = 16;
  localparam int ISA_BANK_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;

  // Register map; each legacy port is two consecutive addresses:
  // even = end-of-interrupt clear, odd = inverted enable byte.
  localparam addr_t A_NAT_MASK  = 4'h0;
  localparam addr_t A_NAT_VEC   = 4'h1;
  localparam addr_t A_ISA_VEC   = 4'h2;
  localparam addr_t A_ISA_PORT0 = 4'h4;
endpackage

// File: rtl/lowest_set_enc.sv
module lowest_set_enc #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    // scan from the top so the lowest set bit is the last one written
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/nat_irq_bank.sv
module nat_irq_bank #(
  parameter int LINES = 16,
  localparam int SH = LINES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line,
  input  logic             mask_wr,
  input  logic [LINES-1:0] mask_wdata,
  input  logic             vec_acc,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] pend_q,
  output logic             lvl_shared,
  output logic             lvl_own
);
  logic [LINES-1:0] mask_n, pend_n;
  logic [SH-1:0]    rise;
  logic             squelch_q, squelch_n;
  logic             shared_n, own_n;

  always_comb begin
    mask_n = mask_wr ? mask_wdata : mask_q;
    pend_n = line;
    rise   = pend_n[SH-1:0] & ~pend_q[SH-1:0];
    if (vec_acc)                squelch_n = 1'b1;
    else if (mask_wr || |rise)  squelch_n = 1'b0;
    else                        squelch_n = squelch_q;
    shared_n = (|(pend_n[SH-1:0] & mask_n[SH-1:0])) & ~squelch_n;
    own_n    = pend_n[SH] & mask_n[SH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      pend_q     <= '0;
      squelch_q  <= 1'b0;
      lvl_shared <= 1'b0;
      lvl_own    <= 1'b0;
    end else begin
      mask_q     <= mask_n;
      pend_q     <= pend_n;
      squelch_q  <= squelch_n;
      lvl_shared <= shared_n;
      lvl_own    <= own_n;
    end
  end
endmodule

// File: rtl/isa_irq_bank.sv
module isa_irq_bank #(
  parameter int LINES  = 16,
  parameter int BANK_W = 8,
  localparam int NB = LINES / BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line,
  input  logic [NB-1:0]     eoi_wr,
  input  logic [NB-1:0]     msk_wr,
  input  logic [BANK_W-1:0] wbyte,
  output logic [LINES-1:0]  en_q,
  output logic [LINES-1:0]  pend_q,
  output logic              lvl
);
  logic [LINES-1:0] en_n, clr, pend_n;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign en_n[b*BANK_W +: BANK_W] = msk_wr[b] ? ~wbyte : en_q[b*BANK_W +: BANK_W];
    assign clr[b*BANK_W +: BANK_W]  = {BANK_W{eoi_wr[b]}};
  end

  assign pend_n = (pend_q | line) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '1;
      pend_q <= '0;
      lvl    <= 1'b0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      lvl    <= |(pend_n & en_n);
    end
  end
endmodule

// File: rtl/intr_cascade_router.sv
module intr_cascade_router
  import intr_router_pkg::*;
#(
  parameter int NAT_N  = NAT_LINES,
  parameter int ISA_N  = ISA_LINES,
  parameter int BANK_W = ISA_BANK_W,
  localparam int NB    = ISA_N / BANK_W,
  localparam int NIW   = $clog2(NAT_N - 1),
  localparam int IIW   = $clog2(ISA_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NAT_N-1:0]  nat_line,
  input  logic [ISA_N-1:0]  isa_line,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_lvl3,
  output logic              irq_lvl4,
  output logic              irq_lvl6
);
  logic [NAT_N-1:0]  nat_mask_q, nat_pend_q;
  logic [ISA_N-1:0]  isa_en_q, isa_pend_q;
  logic              nat_mask_wr, nat_vec_acc;
  logic [NB-1:0]     eoi_wr, msk_wr, msk_rd_hit;
  logic              nat_any, isa_any;
  logic [NIW-1:0]    nat_idx;
  logic [IIW-1:0]    isa_idx;
  logic [DATA_W-1:0] nat_vec, isa_vec, rd_mux, rdata_q;

  assign nat_mask_wr = bus_wr && (bus_addr == A_NAT_MASK);
  assign nat_vec_acc = (bus_rd || bus_wr) && (bus_addr == A_NAT_VEC);

  for (genvar b = 0; b < NB; b++) begin : g_port
    localparam addr_t EOI_A = ADDR_W'(int'(A_ISA_PORT0) + 2 * b);
    localparam addr_t MSK_A = ADDR_W'(int'(A_ISA_PORT0) + 2 * b + 1);
    assign eoi_wr[b]     = bus_wr && (bus_addr == EOI_A);
    assign msk_wr[b]     = bus_wr && (bus_addr == MSK_A);
    assign msk_rd_hit[b] = (bus_addr == MSK_A);
  end

  nat_irq_bank #(.LINES(NAT_N)) u_nat (
    .clk        (clk),
    .rst_n      (rst_n),
    .line       (nat_line),
    .mask_wr    (nat_mask_wr),
    .mask_wdata (bus_wdata[NAT_N-1:0]),
    .vec_acc    (nat_vec_acc),
    .mask_q     (nat_mask_q),
    .pend_q     (nat_pend_q),
    .lvl_shared (irq_lvl3),
    .lvl_own    (irq_lvl6)
  );

  isa_irq_bank #(.LINES(ISA_N), .BANK_W(BANK_W)) u_isa (
    .clk    (clk),
    .rst_n  (rst_n),
    .line   (isa_line),
    .eoi_wr (eoi_wr),
    .msk_wr (msk_wr),
    .wbyte  (bus_wdata[BANK_W-1:0]),
    .en_q   (isa_en_q),
    .pend_q (isa_pend_q),
    .lvl    (irq_lvl4)
  );

  lowest_set_enc #(.W(NAT_N - 1)) u_nat_enc (
    .vec (nat_pend_q[NAT_N-2:0]),
    .any (nat_any),
    .idx (nat_idx)
  );

  lowest_set_enc #(.W(ISA_N)) u_isa_enc (
    .vec (isa_pend_q & isa_en_q),
    .any (isa_any),
    .idx (isa_idx)
  );

  assign nat_vec = nat_any ? DATA_W'((32'(nat_idx) + 32'd1) << 2) : '0;
  assign isa_vec = isa_any ? DATA_W'(isa_idx) : '0;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_NAT_MASK)     rd_mux = DATA_W'(nat_mask_q);
    else if (bus_addr == A_NAT_VEC) rd_mux = nat_vec;
    else if (bus_addr == A_ISA_VEC) rd_mux = isa_vec;
    else if (|msk_rd_hit)           rd_mux = DATA_W'(isa_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk
  import intr_router_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 irq_lvl3,
  input logic                 irq_lvl4,
  input logic                 irq_lvl6,
  input logic [NAT_LINES-1:0] nat_pend,
  input logic [NAT_LINES-1:0] nat_mask,
  input logic [ISA_LINES-1:0] isa_pend,
  input logic [ISA_LINES-1:0] isa_en
);
  // R1
  lvl6_tracks_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl6 == (nat_pend[NAT_LINES-1] && nat_mask[NAT_LINES-1]));

  // R2
  lvl3_needs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl3 |-> |(nat_pend[NAT_LINES-2:0] & nat_mask[NAT_LINES-2:0]));

  // R5
  vec_access_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == A_NAT_VEC) |=> !irq_lvl3);

  // R6
  lvl4_combines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl4 == |(isa_pend & isa_en));

  // R8
  low_mask_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ISA_PORT0 + 4'h1) |=> isa_en[7:0] == ~$past(bus_wdata[7:0]));

  // R9
  low_eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ISA_PORT0) |=> isa_pend[7:0] == 8'h00);
endmodule

bind intr_cascade_router intr_router_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_lvl3  (irq_lvl3),
  .irq_lvl4  (irq_lvl4),
  .irq_lvl6  (irq_lvl6),
  .nat_pend  (nat_pend_q),
  .nat_mask  (nat_mask_q),
  .isa_pend  (isa_pend_q),
  .isa_en    (isa_en_q)
);

// File: tb/intr_cascade_router_tb.sv
module intr_cascade_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] nat_line = '0;
  logic [15:0] isa_line = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_lvl3, irq_lvl4, irq_lvl6;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intr_cascade_router u_dut (
    .clk(clk), .rst_n(rst_n), .nat_line(nat_line), .isa_line(isa_line),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_lvl3(irq_lvl3), .irq_lvl4(irq_lvl4), .irq_lvl6(irq_lvl6)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_nat(logic [15:0] v);
    @(negedge clk); nat_line = v;
    @(negedge clk);
  endtask

  task automatic set_isa(logic [15:0] v);
    @(negedge clk); isa_line = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 reset lvl6", 16'(irq_lvl6), 16'd0);
    chk("R2 reset lvl3", 16'(irq_lvl3), 16'd0);
    chk("R6 reset lvl4", 16'(irq_lvl4), 16'd0);
    rd(4'h0, d); chk("R3 native mask reset", d, 16'h0000);
    rd(4'h5, d); chk("R7 legacy enable reset", d, 16'hFFFF);
  endtask

  task automatic t_timer();
    logic [15:0] d;
    set_nat(16'h8000);
    chk("R1 masked timer", 16'(irq_lvl6), 16'd0);
    wr(4'h0, 16'h8000);
    chk("R1 enabled timer", 16'(irq_lvl6), 16'd1);
    chk("R2 timer not shared", 16'(irq_lvl3), 16'd0);
    rd(4'h1, d);
    chk("R4 line 15 not reported", d, 16'd0);
    chk("R1 vector access keeps lvl6", 16'(irq_lvl6), 16'd1);
    set_nat(16'h0000);
    chk("R1 timer drop", 16'(irq_lvl6), 16'd0);
  endtask

  task automatic t_shared();
    wr(4'h0, 16'h0004);
    set_nat(16'h0020);
    chk("R2 masked line 5", 16'(irq_lvl3), 16'd0);
    set_nat(16'h0024);
    chk("R2 enabled line 2", 16'(irq_lvl3), 16'd1);
    set_nat(16'h0000);
    chk("R2 line 2 drop", 16'(irq_lvl3), 16'd0);
  endtask

  task automatic t_nat_vec();
    logic [15:0] d;
    wr(4'h0, 16'h0000);
    set_nat(16'h0001); rd(4'h1, d); chk("R4 line 0 unmasked", d, 16'd4);
    set_nat(16'h4000); rd(4'h1, d); chk("R4 line 14", d, 16'd60);
    set_nat(16'h1200); rd(4'h1, d); chk("R4 lines 9 and 12", d, 16'd40);
    set_nat(16'h0000); rd(4'h1, d); chk("R4 none pending", d, 16'd0);
  endtask

  task automatic t_ack();
    logic [15:0] d;
    wr(4'h0, 16'h7FFF);
    set_nat(16'h0008);
    chk("R2 line 3 raises", 16'(irq_lvl3), 16'd1);
    rd(4'h1, d);
    chk("R4 line 3 vector", d, 16'd16);
    chk("R5 read acks", 16'(irq_lvl3), 16'd0);
    repeat (3) @(negedge clk);
    chk("R5 stays acked", 16'(irq_lvl3), 16'd0);
    set_nat(16'h0088);
    chk("R5 new line rearms", 16'(irq_lvl3), 16'd1);
    wr(4'h1, 16'hFFFF);
    chk("R5 write acks", 16'(irq_lvl3), 16'd0);
    rd(4'h0, d);
    chk("R11 write to vector ignored", d, 16'h7FFF);
    wr(4'h0, 16'h7FFF);
    chk("R3 mask write rearms", 16'(irq_lvl3), 16'd1);
    set_nat(16'h0000);
    wr(4'h0, 16'h0000);
  endtask

  task automatic t_isa_mask();
    logic [15:0] d;
    wr(4'h5, 16'h000F); rd(4'h5, d); chk("R8 low byte inverted", d, 16'hFFF0);
    wr(4'h7, 16'h00FF); rd(4'h7, d); chk("R8 high byte inverted", d, 16'h00F0);
    wr(4'h7, 16'h0000); wr(4'h5, 16'h0000);
    rd(4'h5, d); chk("R8 restored", d, 16'hFFFF);
  endtask

  task automatic t_isa_pend();
    logic [15:0] d;
    set_isa(16'h0200);
    chk("R6 line 9 raises", 16'(irq_lvl4), 16'd1);
    set_isa(16'h0000);
    chk("R6 sticky after drop", 16'(irq_lvl4), 16'd1);
    rd(4'h2, d); chk("R10 vector 9", d, 16'd9);
    wr(4'h4, 16'h0020);
    chk("R9 low clear spares bit 9", 16'(irq_lvl4), 16'd1);
    wr(4'h6, 16'h0000);
    chk("R9 high clear", 16'(irq_lvl4), 16'd0);
    set_isa(16'h1004); set_isa(16'h0000);
    rd(4'h2, d); chk("R10 lowest is 2", d, 16'd2);
    wr(4'h5, 16'h0004);
    rd(4'h2, d); chk("R10 masked 2 gives 12", d, 16'd12);
    chk("R6 line 12 enabled", 16'(irq_lvl4), 16'd1);
    wr(4'h7, 16'h0010);
    chk("R6 all masked", 16'(irq_lvl4), 16'd0);
    rd(4'h2, d); chk("R10 none enabled", d, 16'd0);
    wr(4'h5, 16'h0000); wr(4'h7, 16'h0000);
    wr(4'h4, 16'h0000); wr(4'h6, 16'h0000);
    set_isa(16'h0002);
    wr(4'h4, 16'h0000);
    chk("R9 clear at edge", 16'(irq_lvl4), 16'd0);
    @(negedge clk);
    chk("R9 held line resets bit", 16'(irq_lvl4), 16'd1);
    set_isa(16'h0000);
    wr(4'h4, 16'h0000);
  endtask

  task automatic t_bus();
    logic [15:0] d;
    wr(4'h0, 16'h00A5);
    rd(4'h3, d); chk("R11 unmapped reads 0", d, 16'd0);
    wr(4'h2, 16'hFFFF);
    rd(4'h0, d); chk("R3 mask readback", d, 16'h00A5);
    repeat (2) @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 16'h00A5);
    rd(4'h2, d); chk("R11 vector write ignored", d, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_shared();
    t_nat_vec();
    t_ack();
    t_isa_mask();
    t_isa_pend();
    t_bus();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule